// File: doc/BRIEF.md
# Preemptive Command Dispatcher with Replay

This block picks, one at a time, the next converter command from a set of triggered command queues. It passes that command to a single local converter. Each queue offers a command word, a valid flag, a triggered flag and an end-of-queue marker. The most significant bit of each command word names the target. Words with that bit clear go to the local converter, and this block handles them. Words with that bit set belong to the slower serial-link path. This block never takes them, so that path runs on its own.

Queue 0 is the urgent queue. When its abort permission is set, a queue 0 command can stop a conversion that another queue started. The block then keeps the interrupted command in a single holding slot and serves queue 0 alone until its urgent run finishes. The run finishes when a queue 0 command marked end-of-queue is issued, or when queue 0 has nothing to offer at an issue opportunity. The held command is then reissued before any other queue is served. When abort permission is clear, queue 0 is simply the highest-priority queue.

The converter side uses a one-cycle issue strobe with a command word and a busy input. A done pulse reports that the conversion has finished, and a one-cycle abort strobe stops a conversion. Issue and queue pops are combinational in the cycle the decision is made. All state updates on the rising clock edge.

Top module: `preempt_dispatch`

## Requirements
- R1: While rst_n is low, conv_issue, conv_abort and every req_pop bit are 0, whatever the inputs. After reset, no command is in flight and no command is held.
- R2: A command is issued only in a cycle when conv_busy is low and no earlier issued command is still in flight. A command stays in flight from its issue until conv_done or conv_abort.
- R3: A queue i is eligible when req_trig[i] and req_valid[i] are both 1 and bit CW-1 of its command word is 0. At a normal issue opportunity, the lowest-numbered eligible queue wins. Its req_pop bit alone is raised, and conv_cmd carries its word.
- R4: A command word with bit CW-1 set is never popped or issued, and a queue holding such a word does not block higher-numbered queues.
- R5: An abort fires when all of these hold: a command from queue 1 or higher is in flight, queue 0 is eligible, q0_abort_en is 1, no command is held, and conv_done is low. An abort raises conv_abort for that cycle, with no issue in that cycle, and it ends the in-flight state.
- R6: With q0_abort_en at 0, conv_abort is never raised. An eligible queue 0 then waits for conv_done.
- R7: After an abort, only queue 0 may be issued until one of two things happens: a queue 0 command whose req_eoq[0] is 1 is issued, or a free cycle finds queue 0 not eligible.
- R8: When the urgent run has ended, the next issue replays the aborted command word. The replay raises no req_pop bit, and it comes ahead of every normal requester.
- R9: A replayed command in flight is never aborted, and only one aborted command is held at a time. An abort request during a replay waits until the replay completes.
- R10: conv_abort is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NQ | Per queue: a command word is present |
| req_trig | input | NQ | Per queue: the queue is triggered |
| req_eoq | input | NQ | Per queue: the offered command ends its queue |
| req_cmd | input | NQ*CW | Command words, queue i in bits [i*CW +: CW], bit CW-1 set means serial-link target |
| q0_abort_en | input | 1 | Queue 0 may abort a conversion in progress |
| req_pop | output | NQ | One-hot pop of the queue whose word is issued |
| conv_issue | output | 1 | Command issue strobe to the converter |
| conv_cmd | output | CW | Command word issued |
| conv_busy | input | 1 | Converter cannot accept a command |
| conv_done | input | 1 | Conversion in flight has finished |
| conv_abort | output | 1 | One-cycle strobe stopping the conversion in flight |

## Verification
A lost or stuck in-flight flag shows at the ports within one free cycle. Either a second issue arrives without a done, or an eligible queue never issues. A corrupted holding slot shows on the first issue after the urgent run ends: the replay has no pop, so a wrong word or a missing replay is seen in that one cycle. An urgent flag that clears late or early shows as a normal queue issued during the urgent run, or as queue 0 kept exclusive after its end-of-queue word. Both appear in the first free cycle after the end condition.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // origin of the command currently held by the converter
  typedef enum logic [1:0] {
    SRC_NORMAL = 2'd0,
    SRC_Q0     = 2'd1,
    SRC_REPLAY = 2'd2
  } src_e;

  // isolate the lowest set bit of a request vector
  function automatic logic [31:0] pick_lowest(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  // a command targets the local converter when its top bit is clear
  function automatic logic is_local(input logic top_bit);
    return ~top_bit;
  endfunction

endpackage

// File: rtl/pd_prio_pick.sv
module pd_prio_pick #(
  parameter int NQ = 4
) (
  input  logic [NQ-1:0] elig,
  output logic [NQ-1:0] grant,
  output logic          any
);
  import pd_pkg::*;

  logic [31:0] wide;

  always_comb begin
    wide  = pick_lowest(32'(elig));
    grant = wide[NQ-1:0];
    any   = |elig;
  end
endmodule

// File: rtl/pd_flight.sv
module pd_flight #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [CW-1:0] issue_cmd,
  input  pd_pkg::src_e  issue_src,
  input  logic          done,
  input  logic          abort,
  output logic          busy_o,
  output logic [CW-1:0] cmd_o,
  output pd_pkg::src_e  src_o
);
  import pd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cmd_o  <= '0;
      src_o  <= SRC_NORMAL;
    end else if (issue) begin
      busy_o <= 1'b1;
      cmd_o  <= issue_cmd;
      src_o  <= issue_src;
    end else if (done || abort) begin
      busy_o <= 1'b0;
    end
  end

  // R2
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !busy_o);
endmodule

// File: rtl/pd_victim_hold.sv
module pd_victim_hold #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [CW-1:0] cap_cmd,
  input  logic          release_i,
  output logic          valid_o,
  output logic [CW-1:0] cmd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      cmd_o   <= '0;
    end else if (capture) begin
      valid_o <= 1'b1;
      cmd_o   <= cap_cmd;
    end else if (release_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9
  one_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !valid_o);
endmodule

// File: rtl/preempt_dispatch.sv
module preempt_dispatch #(
  parameter int NQ = 4,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    req_valid,
  input  logic [NQ-1:0]    req_trig,
  input  logic [NQ-1:0]    req_eoq,
  input  logic [NQ*CW-1:0] req_cmd,
  input  logic             q0_abort_en,
  output logic [NQ-1:0]    req_pop,
  output logic             conv_issue,
  output logic [CW-1:0]    conv_cmd,
  input  logic             conv_busy,
  input  logic             conv_done,
  output logic             conv_abort
);
  import pd_pkg::*;

  localparam int TOP = CW - 1;

  logic [CW-1:0] cmd_a [NQ];
  logic [NQ-1:0] local_m;
  logic [NQ-1:0] elig;
  logic [NQ-1:0] grant;
  logic          grant_any;

  // named internal events
  logic          fl_busy;
  logic [CW-1:0] fl_cmd;
  src_e          fl_src;
  logic          hold_valid;
  logic [CW-1:0] hold_cmd;
  logic          urgent_q;
  logic          free_slot;
  logic          q0_elig;
  logic          abort_fire;
  logic          take_q0_urgent;
  logic          take_replay;
  logic          take_normal;
  logic          urgent_end;
  logic [CW-1:0] pick_cmd;
  src_e          issue_src;

  for (genvar i = 0; i < NQ; i++) begin : g_unpack
    assign cmd_a[i]   = req_cmd[i*CW +: CW];
    assign local_m[i] = is_local(cmd_a[i][TOP]);
    // R4
    no_remote_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_pop[i] |-> !cmd_a[i][TOP]);
  end

  assign elig = req_valid & req_trig & local_m;

  pd_prio_pick #(.NQ(NQ)) u_pick (
    .elig  (elig),
    .grant (grant),
    .any   (grant_any)
  );

  always_comb begin
    q0_elig        = elig[0];
    free_slot      = rst_n && !fl_busy && !conv_busy;
    abort_fire     = rst_n && fl_busy && (fl_src == SRC_NORMAL) && !conv_done
                     && q0_abort_en && q0_elig && !hold_valid;
    take_q0_urgent = free_slot && urgent_q && q0_elig;
    take_replay    = free_slot && hold_valid && !take_q0_urgent;
    take_normal    = free_slot && !take_q0_urgent && !take_replay && grant_any;
    urgent_end     = (take_q0_urgent && req_eoq[0]) ||
                     (free_slot && urgent_q && !q0_elig);

    if (take_q0_urgent)   req_pop = NQ'(1);
    else if (take_normal) req_pop = grant;
    else                  req_pop = '0;

    pick_cmd = '0;
    for (int i = 0; i < NQ; i++)
      if (req_pop[i]) pick_cmd = pick_cmd | cmd_a[i];

    conv_issue = take_q0_urgent || take_replay || take_normal;
    conv_cmd   = take_replay ? hold_cmd : pick_cmd;
    conv_abort = abort_fire;

    if (take_replay)     issue_src = SRC_REPLAY;
    else if (req_pop[0]) issue_src = SRC_Q0;
    else                 issue_src = SRC_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          urgent_q <= 1'b0;
    else if (abort_fire) urgent_q <= 1'b1;
    else if (urgent_end) urgent_q <= 1'b0;
  end

  pd_flight #(.CW(CW)) u_flight (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (conv_issue),
    .issue_cmd (conv_cmd),
    .issue_src (issue_src),
    .done      (conv_done),
    .abort     (abort_fire),
    .busy_o    (fl_busy),
    .cmd_o     (fl_cmd),
    .src_o     (fl_src)
  );

  pd_victim_hold #(.CW(CW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (abort_fire),
    .cap_cmd   (fl_cmd),
    .release_i (take_replay),
    .valid_o   (hold_valid),
    .cmd_o     (hold_cmd)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!conv_issue && !conv_abort && req_pop == '0));
  // R2
  issue_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_issue |-> !conv_busy);
  // R3
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_pop) && (req_pop != '0 -> conv_issue));
  // R5
  abort_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> !conv_issue);
  // R6
  no_abort_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q0_abort_en |-> !conv_abort);
  // R7
  urgent_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_q && conv_issue) |-> (req_pop == NQ'(1) || req_pop == '0));
  // R8
  replay_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !urgent_q && conv_issue) |-> req_pop == '0);
  // R10
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_abort);
endmodule

// File: tb/preempt_dispatch_test.sv
`timescale 1ns/1ps
module preempt_dispatch_test;
  localparam int NQ = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NQ-1:0] req_valid, req_trig, req_eoq, hi;
  logic [14:0] lo [NQ];
  logic [NQ*CW-1:0] req_cmd;
  logic q0_abort_en, conv_busy, conv_done;
  logic [NQ-1:0] req_pop;
  logic conv_issue, conv_abort;
  logic [CW-1:0] conv_cmd;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NQ; i++) req_cmd[i*CW +: CW] = {hi[i], lo[i]};

  preempt_dispatch #(.NQ(NQ), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_trig(req_trig),
    .req_eoq(req_eoq), .req_cmd(req_cmd), .q0_abort_en(q0_abort_en),
    .req_pop(req_pop), .conv_issue(conv_issue), .conv_cmd(conv_cmd),
    .conv_busy(conv_busy), .conv_done(conv_done), .conv_abort(conv_abort)
  );

  // {trig, valid, hi, expected pop}
  localparam logic [15:0] VEC [8] = '{
    16'hFF0_1, 16'hEF0_2, 16'hF60_2, 16'hFF1_2,
    16'hCE4_8, 16'hFFF_0, 16'h0F0_0, 16'h880_8
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic quiet();
    req_trig = '0; req_valid = '0; req_eoq = '0; hi = '0;
  endtask

  // one cycle of conv_done with no requesters, then back to idle
  task automatic finish_conv();
    @(negedge clk); quiet(); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); q0_abort_en = 1'b0; conv_busy = 1'b0; conv_done = 1'b0;
    for (int i = 0; i < NQ; i++) lo[i] = 15'(16'h0100 * (i + 1));
    // R1: requests present during reset must not issue
    req_trig = '1; req_valid = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 issue", conv_issue, 0);
    chk("R1 pop", req_pop, 0);
    chk("R1 abort", conv_abort, 0);
    quiet(); rst_n = 1'b1;

    // R3 R4: priority table walked in idle slots
    for (int v = 0; v < 8; v++) begin
      logic [3:0] ep;
      int w;
      @(negedge clk);
      req_trig = VEC[v][15:12]; req_valid = VEC[v][11:8]; hi = VEC[v][7:4];
      ep = VEC[v][3:0];
      for (int i = 0; i < NQ; i++) lo[i] = 15'(16'h0100 * (i + 1) + v);
      #1;
      chk("R3 pop", req_pop, ep);
      chk("R4 issue", conv_issue, ep != 0);
      w = 0;
      for (int i = NQ - 1; i >= 0; i--) if (ep[i]) w = i;
      if (ep != 0) chk("R3 cmd", conv_cmd, {1'b0, lo[w]});
      finish_conv();
    end

    // R2: busy converter and in-flight command block issue
    req_trig = 4'h2; req_valid = 4'h2; conv_busy = 1'b1; lo[1] = 15'h0A11;
    #1; chk("R2 busy", conv_issue, 0);
    @(negedge clk); conv_busy = 1'b0;
    #1; chk("R2 free pop", req_pop, 4'h2);
    @(negedge clk); #1;
    chk("R2 in flight", conv_issue, 0);
    finish_conv();

    // R5 R7 R8 R9 R10: abort, urgent run ending on end-of-queue, replay
    req_trig = 4'h4; req_valid = 4'h4; lo[2] = 15'h0B22;
    #1; chk("R5 victim issue", req_pop, 4'h4);
    @(negedge clk);
    req_trig = 4'h3; req_valid = 4'h3; lo[0] = 15'h0C01; lo[1] = 15'h0C11;
    q0_abort_en = 1'b1;
    #1;
    chk("R5 abort", conv_abort, 1);
    chk("R5 no issue", conv_issue, 0);
    @(negedge clk); #1;
    chk("R10 abort single", conv_abort, 0);
    chk("R7 urgent pop", req_pop, 4'h1);
    chk("R7 urgent cmd", conv_cmd, 16'h0C01);
    @(negedge clk); lo[0] = 15'h0C02; req_eoq = 4'h1; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    #1;
    chk("R7 second urgent", req_pop, 4'h1);
    chk("R7 second cmd", conv_cmd, 16'h0C02);
    @(negedge clk); req_trig = 4'h2; req_valid = 4'h2; req_eoq = '0; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    #1;
    chk("R8 replay issue", conv_issue, 1);
    chk("R8 replay no pop", req_pop, 0);
    chk("R8 replay cmd", conv_cmd, 16'h0B22);
    @(negedge clk); req_trig = 4'h3; req_valid = 4'h3;
    #1; chk("R9 no abort of replay", conv_abort, 0);
    @(negedge clk); #1;
    chk("R9 still waiting", conv_abort, 0);
    chk("R9 no issue", conv_issue, 0);
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    #1; chk("R9 q0 after replay", req_pop, 4'h1);
    finish_conv();

    // R7 R8: urgent run ends because queue 0 is empty
    req_trig = 4'h8; req_valid = 4'h8; lo[3] = 15'h0D33;
    #1; chk("R3 q3 issue", req_pop, 4'h8);
    @(negedge clk); req_trig = 4'h1; req_valid = 4'h1;
    #1; chk("R5 abort q3", conv_abort, 1);
    @(negedge clk); req_trig = 4'h2; req_valid = 4'h2;
    #1;
    chk("R7 empty end replay pop", req_pop, 0);
    chk("R8 replay cmd empty", conv_cmd, 16'h0D33);
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    #1; chk("R3 normal resumes", req_pop, 4'h2);
    finish_conv();

    // R6: abort disabled
    q0_abort_en = 1'b0;
    req_trig = 4'h4; req_valid = 4'h4;
    #1; chk("R6 start", req_pop, 4'h4);
    @(negedge clk); req_trig = 4'h1; req_valid = 4'h1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R6 no abort", conv_abort, 0);
      chk("R6 no issue", conv_issue, 0);
      @(negedge clk);
    end
    conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    #1; chk("R6 q0 after done", req_pop, 4'h1);
    finish_conv();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule